// File: doc/BRIEF.md
# Triplicated Majority and Minority Voter Stage

This block joins three redundant copies of a multi-bit result into three voted outputs, one for each redundancy domain. Each domain has its own bitwise two-of-three majority voter, so a fault in any one voter is masked like a fault in a module. Each domain also has its own minority detector. The detector clears that domain's output-enable on every bit where the domain's own copy differs from the other two copies, which agree with each other. Because of this, the three output pins can be tied together outside the chip: a domain that disagrees on a bit stops driving that bit.

Voting works bit by bit. Faults in different copies that hit different bit positions are all masked. Each domain also reports one disagreement flag, registered on its own clock. Each domain has its own clock and reset, and the domains share only the three data copies.

Top module: `tmr_voter_stage`

## Requirements
- R1: Each domain's voted output is, bit by bit, the value held by at least two of the three copies. It is combinational, so it changes in the same cycle as the copies.
- R2: The three domains always present identical voted values.
- R3: When the copies each differ from the majority on different bit positions (for example copy0=001, copy1=010, copy2=100), all voted outputs still equal the majority (000).
- R4: Enable bit i of domain d is active high. It is 0 exactly when copy d bit i differs from the other two copies' bit i and those two agree with each other. Otherwise it is 1.
- R5: When all three copies are equal, every enable bit of every domain is 1. Every disagreement flag reads 0 after the next rising edge of that domain's clock.
- R6: At any bit position, at most one domain has its enable at 0.
- R7: The disagreement flag of domain d is the OR of domain d's per-bit minority results. It is sampled on the rising edge of that domain's clock, so it lags the copies by that one edge.
- R8: The reset of domain d is active low and asynchronous. It clears only flag d. The other domains' flags keep their values.
- R9: The voted outputs and the enables follow the copies even while the resets are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkDom | input | 3 | Clock for each domain, bit d for domain d |
| rstDomN | input | 3 | Asynchronous active-low reset for each domain |
| copyIn | input | 3 x WIDTH | The three redundant copies of the result; copyIn[d] is domain d's copy |
| voteOut | output | 3 x WIDTH | Majority value for each domain |
| pinEn | output | 3 x WIDTH | Active-high output-enable for each domain, per bit |
| disagreeFlag | output | 3 | Registered disagreement flag for each domain |

## Verification
In one cycle, the combinational vote and enable update for a new set of copies, while each domain's flag still holds the minority result of the previous set until its own clock edge. To provoke this, the bench applies every combination of three 3-bit copies just after a clock edge. It checks the vote and enables at once against the previous expected flags, then checks the new flags after all three staggered clocks have risen. A reset asserted in one domain while all three flags are high is judged by confirming that the other two flags hold their value.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int DOMAINS = 3;

  typedef struct packed {
    logic minorHit;
    logic allAgree;
  } voteStatus_t;
endpackage

// File: rtl/tmr_vote_slice.sv
module tmr_vote_slice
  import tmr_vote_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] localCopy,
  input  logic [WIDTH-1:0] peerA,
  input  logic [WIDTH-1:0] peerB,
  output logic [WIDTH-1:0] voteOut,
  output logic [WIDTH-1:0] pinEn,
  output voteStatus_t      status
);
  logic [WIDTH-1:0] minorMask;

  // Per-bit majority and minority detection
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign voteOut[i]   = (localCopy[i] & peerA[i]) | (localCopy[i] & peerB[i]) |
                          (peerA[i] & peerB[i]);
    assign minorMask[i] = (localCopy[i] ^ peerA[i]) & ~(peerA[i] ^ peerB[i]);
  end

  assign pinEn           = ~minorMask;
  assign status.minorHit = |minorMask;
  assign status.allAgree = (localCopy == peerA) && (peerA == peerB);

  // R1: the vote never disagrees with two copies on the same bit
  assert_vote_majority_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((((voteOut ^ localCopy) & (voteOut ^ peerA)) |
      ((voteOut ^ localCopy) & (voteOut ^ peerB)) |
      ((voteOut ^ peerA) & (voteOut ^ peerB))) == '0));

  // R4: a driven bit always carries the local copy's value
  assert_enabled_bits_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    (((voteOut ^ localCopy) & pinEn) == '0));
endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tmr_vote_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  voteStatus_t status,
  output logic        flag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= status.minorHit;
  end

  // R7: flag follows the minority result one edge later
  assert_flag_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    status.minorHit |=> flag);

  // R5: agreement clears the flag on the next edge
  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    status.allAgree |=> !flag);
endmodule

// File: rtl/tmr_voter_stage.sv
module tmr_voter_stage
  import tmr_vote_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [DOMAINS-1:0]            clkDom,
  input  logic [DOMAINS-1:0]            rstDomN,
  input  logic [DOMAINS-1:0][WIDTH-1:0] copyIn,
  output logic [DOMAINS-1:0][WIDTH-1:0] voteOut,
  output logic [DOMAINS-1:0][WIDTH-1:0] pinEn,
  output logic [DOMAINS-1:0]            disagreeFlag
);
  voteStatus_t domStatus [DOMAINS];

  for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
    localparam int PEER_A = (d + 1) % DOMAINS;
    localparam int PEER_B = (d + 2) % DOMAINS;

    tmr_vote_slice #(.WIDTH(WIDTH)) u_slice (
      .clk      (clkDom[d]),
      .rstN     (rstDomN[d]),
      .localCopy(copyIn[d]),
      .peerA    (copyIn[PEER_A]),
      .peerB    (copyIn[PEER_B]),
      .voteOut  (voteOut[d]),
      .pinEn    (pinEn[d]),
      .status   (domStatus[d])
    );

    tmr_flag_ctrl u_ctrl (
      .clk   (clkDom[d]),
      .rstN  (rstDomN[d]),
      .status(domStatus[d]),
      .flag  (disagreeFlag[d])
    );
  end

  // R2: independent voters agree
  assert_domains_agree_R2: assert property (@(posedge clkDom[0]) disable iff (!rstDomN[0])
    (voteOut[0] == voteOut[1]) && (voteOut[1] == voteOut[2]));

  // R6: per bit, at most one domain releases its pin
  for (genvar i = 0; i < WIDTH; i++) begin : g_excl
    assert_single_minority_R6: assert property (@(posedge clkDom[0]) disable iff (!rstDomN[0])
      $countones({~pinEn[2][i], ~pinEn[1][i], ~pinEn[0][i]}) <= 1);
  end
endmodule

// File: tb/tmr_voter_stage_tb.sv
`timescale 1ns/100ps
module tmr_voter_stage_tb;
  localparam int W = 3;

  logic clk0, clk1, clk2;
  logic [2:0]        clkDom;
  logic [2:0]        rstDomN;
  logic [2:0][W-1:0] copyIn;
  logic [2:0][W-1:0] voteOut;
  logic [2:0][W-1:0] pinEn;
  logic [2:0]        disagreeFlag;

  int checks = 0;
  int errors = 0;

  assign clkDom = {clk2, clk1, clk0};

  tmr_voter_stage #(.WIDTH(W)) u_dut (
    .clkDom(clkDom), .rstDomN(rstDomN), .copyIn(copyIn),
    .voteOut(voteOut), .pinEn(pinEn), .disagreeFlag(disagreeFlag)
  );

  // 125 MHz domain clocks with staggered phases: rises at 4, 6 and 1 mod 8
  initial begin clk0 = 0; forever #4 clk0 = ~clk0; end
  initial begin clk1 = 0; #2; forever #4 clk1 = ~clk1; end
  initial begin clk2 = 0; #1 clk2 = 1; forever #4 clk2 = ~clk2; end

  function automatic logic [W-1:0] expVote(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
    return r;
  endfunction

  function automatic logic [W-1:0] expEn(logic [W-1:0] l, logic [W-1:0] p, logic [W-1:0] q);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = !((l[i] != p[i]) && (p[i] == q[i]));
    return r;
  endfunction

  function automatic logic [2:0] expFlags(logic [2:0][W-1:0] c);
    logic [2:0] r;
    for (int d = 0; d < 3; d++) r[d] = |(~expEn(c[d], c[(d+1)%3], c[(d+2)%3]));
    return r;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkComb(string req);
    logic [W-1:0] v;
    v = expVote(copyIn[0], copyIn[1], copyIn[2]);
    for (int d = 0; d < 3; d++) begin
      check(req == "" ? "R1" : req, $sformatf("vote dom%0d", d), int'(voteOut[d]), int'(v));
      check(req == "" ? "R4" : req, $sformatf("enable dom%0d", d), int'(pinEn[d]),
            int'(expEn(copyIn[d], copyIn[(d+1)%3], copyIn[(d+2)%3])));
    end
    check("R2", "domains agree", int'(voteOut[0] == voteOut[1] && voteOut[1] == voteOut[2]), 1);
    for (int i = 0; i < W; i++)
      check("R6", $sformatf("released pins bit%0d", i),
            int'(!pinEn[0][i]) + int'(!pinEn[1][i]) + int'(!pinEn[2][i]) <= 1 ? 1 : 0, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] prevFlags;
    logic [2:0] newFlags;
    bit allEq;
    rstDomN = 3'b000;
    copyIn = '0;
    copyIn[0] = 3'b001;
    #20.5;
    // R8 reset state; R9 outputs live during reset
    check("R8", "flags in reset", int'(disagreeFlag), 0);
    checkComb("R9");

    @(posedge clk0); #1 rstDomN = 3'b111;
    prevFlags = expFlags(copyIn);
    @(posedge clk0);

    // Exhaustive sweep of all copy combinations
    for (int v = 0; v < 512; v++) begin
      @(posedge clk0); #1;
      copyIn[0] = v[2:0];
      copyIn[1] = v[5:3];
      copyIn[2] = v[8:6];
      #0.5;
      checkComb("");
      check("R7", "flags lag one edge", int'(disagreeFlag), int'(prevFlags));
      newFlags = expFlags(copyIn);
      allEq = (copyIn[0] == copyIn[1]) && (copyIn[1] == copyIn[2]);
      if (allEq) check("R5", "all enables when equal", int'(&pinEn), 1);
      @(posedge clk0); #1;
      check(allEq ? "R5" : "R7", "flags after edge", int'(disagreeFlag), int'(newFlags));
      prevFlags = newFlags;
    end

    // R3: faults on different bits in different copies
    @(posedge clk0); #1;
    copyIn[0] = 3'b001; copyIn[1] = 3'b010; copyIn[2] = 3'b100;
    #0.5;
    checkComb("R3");
    check("R3", "masked vote", int'(voteOut[1]), 0);
    @(posedge clk0); #1;
    check("R7", "all flags set", int'(disagreeFlag), 7);

    // R8: reset one domain only
    rstDomN[1] = 1'b0;
    #0.5;
    check("R8", "domain1 reset alone", int'(disagreeFlag), 5);
    @(posedge clk0); @(posedge clk0); #1;
    check("R8", "others keep flags", int'(disagreeFlag), 5);
    checkComb("R9");
    rstDomN[1] = 1'b1;
    @(posedge clk0); #1;
    check("R8", "domain1 flag back after release", int'(disagreeFlag), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule